// File: doc/BRIEF.md
# Quad-Channel DAC Parallel Register Bank

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter fed from a parallel bus. A host places a code on the 8-bit data bus and a channel number on the 2-bit address, then pulls the active-low write strobe. Each channel has two register stages. The first stage is a per-channel input register, reached through the address. The second is a DAC register that holds the code presented to the converter.

A separate active-low load strobe moves every input register into its DAC register at once. The host can therefore prepare all four channels and then update them together. Both stages act as level-sensitive latches, modelled in the system clock domain. A strobe that is low during a cycle makes its stage take its source value at the end of that cycle. A strobe that is high leaves the stage holding its contents. When both strobes are low together, the bus value reaches the addressed DAC register in one step.

Top module: `quad_dac_latch_bank`

## Requirements
- R1: When the reset input is low, all four input registers and all four DAC outputs are zero. This holds both at start-up and for a reset applied in mid-operation.
- R2: In a cycle with the write strobe low, the input register picked by the address takes the bus value at the next clock edge. The other three input registers keep their contents.
- R3: In a cycle with the write strobe high, no input register changes, whatever the bus or the address carry.
- R4: In a cycle with the load strobe low, every DAC output takes the value its input register has at the end of that cycle, at the next clock edge.
- R5: In a cycle with the load strobe high, every DAC output keeps its previous value, whatever the write activity.
- R6: In a cycle with both strobes low, the addressed DAC output equals the bus value after the next edge. The output follows the bus from cycle to cycle for as long as both strobes stay low.
- R7: After the write strobe returns high, the input register keeps the last bus value it took while the strobe was low. Later bus changes do not alter it.
- R8: Address value 0 selects channel A, 1 selects B, 2 selects C and 3 selects D. The channel number k is carried on dac_codes bits [8k+7:8k]. At most one channel is selected in any cycle.
- R9: After the load strobe returns high, the DAC outputs keep the values they held at that moment, even when the input registers change afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears both register stages |
| bus_data | input | 8 | Parallel data bus; bit 7 is the MSB |
| chan_addr | input | 2 | Channel address (0=A, 1=B, 2=C, 3=D) |
| wr_n | input | 1 | Active-low write strobe for the addressed input register |
| load_n | input | 1 | Active-low load strobe for all DAC registers |
| dac_codes | output | 32 | Four DAC register values, channel k at bits [8k+7:8k] |

## Verification
A write and a load can happen in the same cycle, and then the bus value must reach the addressed DAC register in a single edge. The bench provokes this by holding both strobes low on channel C while it changes the bus value in consecutive cycles. Each cycle it expects the C lane to show that cycle's bus value and the other three lanes to show their input registers. A further case raises the load strobe while writing continues, to confirm that the outputs stay frozen at the values they held when the load ended.

// File: rtl/qdl_pkg.sv
package qdl_pkg;
    localparam int DEF_DATA_W = 8;
    localparam int DEF_NUM_CH = 4;
endpackage

// File: rtl/qdl_addr_decode.sv
module qdl_addr_decode #(
    parameter int NUM_CH = qdl_pkg::DEF_NUM_CH,
    parameter int ADDR_W = $clog2(NUM_CH)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_n,
    output logic [NUM_CH-1:0] sel
);
    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        always_comb begin
            sel[i] = !wr_n && (addr == ADDR_W'(i));
        end
    end
endmodule

// File: rtl/qdl_input_bank.sv
module qdl_input_bank #(
    parameter int DATA_W = qdl_pkg::DEF_DATA_W,
    parameter int NUM_CH = qdl_pkg::DEF_NUM_CH,
    localparam int FLAT_W = DATA_W * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] sel,
    input  logic [DATA_W-1:0] bus,
    output logic [FLAT_W-1:0] in_next,
    output logic [FLAT_W-1:0] in_cur
);
    typedef struct packed {
        logic [NUM_CH-1:0][DATA_W-1:0] lane;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel[i]) st_d.lane[i] = bus;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_next = st_d;
    assign in_cur  = st_q;

    // R3: no selection, no change
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |=> $stable(in_cur));
endmodule

// File: rtl/qdl_dac_bank.sv
module qdl_dac_bank #(
    parameter int DATA_W = qdl_pkg::DEF_DATA_W,
    parameter int NUM_CH = qdl_pkg::DEF_NUM_CH,
    localparam int FLAT_W = DATA_W * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic [FLAT_W-1:0] src,
    output logic [FLAT_W-1:0] dac
);
    typedef struct packed {
        logic [FLAT_W-1:0] codes;
    } dac_t;

    dac_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!load_n) st_d.codes = src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dac = st_q.codes;

    // R5 / R9: load strobe high freezes outputs
    p_load_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_n |=> $stable(dac));
endmodule

// File: rtl/quad_dac_latch_bank.sv
module quad_dac_latch_bank #(
    parameter int DATA_W = qdl_pkg::DEF_DATA_W,
    parameter int NUM_CH = qdl_pkg::DEF_NUM_CH,
    localparam int ADDR_W = $clog2(NUM_CH),
    localparam int FLAT_W = DATA_W * NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_data,
    input  logic [ADDR_W-1:0] chan_addr,
    input  logic              wr_n,
    input  logic              load_n,
    output logic [FLAT_W-1:0] dac_codes
);
    logic [NUM_CH-1:0] sel;
    logic [FLAT_W-1:0] in_next, in_cur;

    qdl_addr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr(chan_addr), .wr_n(wr_n), .sel(sel)
    );

    qdl_input_bank #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_in (
        .clk(clk), .rst_n(rst_n), .sel(sel), .bus(bus_data),
        .in_next(in_next), .in_cur(in_cur)
    );

    qdl_dac_bank #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_dac (
        .clk(clk), .rst_n(rst_n), .load_n(load_n), .src(in_next),
        .dac(dac_codes)
    );

    // R8: decoder never selects more than one lane
    p_sel_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    // R4: load without write copies the held input registers
    p_load_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && wr_n) |=> (dac_codes == $past(in_cur)));

    // R6: both strobes low give a direct bus-to-output path
    p_direct_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && !wr_n) |=>
        (dac_codes[$past(chan_addr)*DATA_W +: DATA_W] == $past(bus_data)));

    // R2: write lands in the addressed input register
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |=> (in_cur[$past(chan_addr)*DATA_W +: DATA_W] == $past(bus_data)));
endmodule

// File: tb/tb_quad_dac_latch_bank.sv
`timescale 1ns/1ps
module tb_quad_dac_latch_bank;
    localparam int W = 8;
    localparam int N = 4;

    typedef struct {
        logic [N*W-1:0] val;
        string          tag;
    } exp_t;

    logic           clk = 0;
    logic           rst_n = 0;
    logic [W-1:0]   bus_data = '0;
    logic [1:0]     chan_addr = '0;
    logic           wr_n = 1;
    logic           load_n = 1;
    logic [N*W-1:0] dac_codes;

    exp_t           sb[$];
    logic [W-1:0]   m_in [N];
    logic [W-1:0]   m_dac[N];
    int             n_chk = 0;
    int             n_fail = 0;
    bit             done = 0;

    quad_dac_latch_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .chan_addr(chan_addr),
        .wr_n(wr_n), .load_n(load_n), .dac_codes(dac_codes)
    );

    always #2 clk = ~clk;

    function automatic logic [N*W-1:0] pack_model();
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = m_dac[i];
        return v;
    endfunction

    task automatic check(input logic [N*W-1:0] act, input logic [N*W-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] a, input logic [W-1:0] d,
                        input logic wr, input logic ld, input string tag);
        exp_t it;
        @(negedge clk);
        chan_addr = a; bus_data = d; wr_n = wr; load_n = ld;
        if (!wr) m_in[a] = d;
        if (!ld) for (int i = 0; i < N; i++) m_dac[i] = m_in[i];
        it.val = pack_model();
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin m_in[i] = '0; m_dac[i] = '0; end
    endtask

    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            check(dac_codes, it.val, it.tag);
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        check(dac_codes, '0, "R1 start-up reset");
        rst_n = 1;

        // R2/R5: fill input registers, load high keeps outputs at zero
        step(2'd0, 8'h11, 0, 1, "R5 write A load high");
        step(2'd1, 8'h22, 0, 1, "R5 write B load high");
        step(2'd2, 8'h33, 0, 1, "R5 write C load high");
        step(2'd3, 8'h44, 0, 1, "R5 write D load high");
        // R3: bus noise with write high
        step(2'd1, 8'hEE, 1, 1, "R3 bus noise wr high");
        step(2'd2, 8'h5A, 1, 1, "R3 bus noise wr high");
        // R4/R8: load copies all lanes, lane order checked
        step(2'd0, 8'hCC, 1, 0, "R4 R8 load lanes");
        step(2'd0, 8'hCC, 1, 1, "R9 load released");
        // R7: held value after write strobe rises
        step(2'd0, 8'hAA, 0, 1, "R5 write A while frozen");
        step(2'd0, 8'h55, 1, 1, "R7 bus change after write");
        step(2'd0, 8'h0F, 1, 0, "R7 load shows held A");
        // R6: transparent path, following the bus
        step(2'd2, 8'h9C, 0, 0, "R6 direct path C");
        step(2'd2, 8'h3E, 0, 0, "R6 follow bus C");
        step(2'd2, 8'hF1, 0, 0, "R6 follow bus C");
        // R9: load up, writes continue, outputs frozen
        step(2'd1, 8'h77, 0, 1, "R9 frozen after load");
        step(2'd3, 8'h88, 0, 1, "R9 frozen after load");
        step(2'd3, 8'h00, 1, 0, "R2 load reveals B and D");
        // R2: extreme codes on every lane
        step(2'd0, 8'hFF, 0, 1, "R2 write A max");
        step(2'd1, 8'h00, 0, 1, "R2 write B zero");
        step(2'd2, 8'h80, 0, 1, "R2 write C msb");
        step(2'd3, 8'h01, 0, 1, "R2 write D lsb");
        step(2'd0, 8'h00, 1, 0, "R2 R8 load extremes");
        step(2'd0, 8'h00, 1, 1, "R5 idle");
        repeat (2) @(negedge clk);

        // R1: reset in mid-operation
        wr_n = 1; load_n = 1;
        rst_n = 0;
        #1;
        check(dac_codes, '0, "R1 mid-run reset");
        model_clear();
        @(negedge clk);
        rst_n = 1;
        step(2'd0, 8'h00, 1, 0, "R1 input registers cleared");
        repeat (2) @(negedge clk);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule